// File: doc/BRIEF.md
# DMA Command FIS Sequencer

This block is the host-side transport-layer controller for one non-queued ATA DMA command at a time. A command request gives an opcode, a direction flag and a sector count. The block then asks the link layer to send a host-to-device Register FIS carrying that opcode. After that it follows the frame types the device sends back until the command closes.

A read accepts any number of incoming Data FIS. A write sends one outgoing Data FIS for each DMA Activate it receives. The length of each outgoing Data FIS is the smaller of the remaining byte count and the per-frame limit. On either path, a device-to-host Register FIS ends the command at once. The block then gives a one-cycle done pulse, with an error flag taken from the returned status. A frame type that does not fit the current state also ends the command, with the error flag set.

The block sees only the frame type byte and a few header fields, on valid/ready streams. Framing, CRC, scrambling and the physical layer sit elsewhere.

States:
- `ST_IDLE`: waiting for a request.
- `ST_CMD`: offering the command frame.
- `ST_RD_WAIT`: receiving read data.
- `ST_WR_WAIT`: waiting for an activate.
- `ST_WR_DATA`: offering one Data FIS.
- `ST_FINISH`: the done cycle.

Transitions:
- IDLE→CMD on an accepted request.
- CMD→RD_WAIT or CMD→WR_WAIT when the command frame is taken.
- RD_WAIT→RD_WAIT on a Data FIS.
- WR_WAIT→WR_DATA on an activate while bytes remain.
- WR_DATA→WR_WAIT when the Data FIS is taken.
- RD_WAIT or WR_WAIT→FINISH on status or on an unexpected type.
- FINISH→IDLE always.

Top module: `dma_fis_seq`

## Requirements
- R1: After reset the block is idle: `cmd_ready`=1, `busy`=0, `tx_valid`=0, `rx_ready`=0 and `done`=0.
- R2: The cycle after a request is accepted, `tx_valid` rises with `tx_type`=0x27, `tx_opcode` set to the request opcode and `tx_write` set to the request direction. These values are held until `tx_ready`.
- R3: While a command is in progress, `cmd_ready` is 0 and a raised `cmd_valid` has no effect: no new frame is offered, and the next accepted command carries its own opcode.
- R4: During a read, incoming type 0x46 (Data FIS) frames are accepted (`rx_ready`=1) any number of times without ending the command.
- R5: An incoming type 0x34 (device-to-host Register FIS) in a wait state ends the command. One cycle later `done` is 1 for exactly one cycle, and `done_err` equals bit 0 (ERR) of `rx_status`.
- R6: During a write, no Data FIS is offered before a type 0x39 (DMA Activate) arrives. Exactly one type 0x46 frame is offered per activate, and `rx_ready` is 0 while it is offered.
- R7: A write moves sectors×512 bytes. Each outgoing Data FIS has `tx_len` = min(remaining bytes, 8192), and the remainder drops by that amount.
- R8: A type that does not fit the state ends the command with `done_err`=1. Such types are 0x39 during a read, 0x46 or 0x27 while waiting on a write, and 0x39 when no bytes remain.
- R9: In the cycle after `done`, the block is idle again with `cmd_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High only when idle |
| cmd_opcode | input | 8 | ATA command opcode |
| cmd_write | input | 1 | 1 = DMA write, 0 = DMA read |
| cmd_sectors | input | SEC_W | Sector count (512-byte sectors) |
| tx_valid | output | 1 | Frame request to link layer |
| tx_ready | input | 1 | Link layer takes the frame |
| tx_type | output | 8 | Frame type, 0x27 or 0x46 |
| tx_opcode | output | 8 | Opcode for the command frame |
| tx_write | output | 1 | Direction for the command frame |
| tx_len | output | LEN_W | Byte length of an outgoing Data FIS |
| rx_valid | input | 1 | Incoming frame header present |
| rx_ready | output | 1 | Block consumes the header |
| rx_type | input | 8 | Incoming frame type |
| rx_status | input | 8 | Status byte of a device-to-host Register FIS |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Error flag, valid with `done` |
| busy | output | 1 | Command in progress |

## Verification
The hardest case to reach from the ports is the final cut-short Data FIS of a long write. The block must count down through several full 8192-byte frames and then trim the last one. A second hard case is an activate that arrives after the remainder is already zero. The bench reaches the first case by sweeping the write length over every sector count from 1 to 40, with a device model that answers each Data FIS with a fresh activate. That sweep crosses the 16-sector frame boundary twice and checks each length against an arithmetic expectation. The zero-remainder case is reached with a zero-sector write, and early status is injected after a chosen number of frames.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
    localparam logic [7:0] FIS_REG_H2D = 8'h27;
    localparam logic [7:0] FIS_REG_D2H = 8'h34;
    localparam logic [7:0] FIS_DMA_ACT = 8'h39;
    localparam logic [7:0] FIS_DATA    = 8'h46;

    localparam int STATUS_ERR_BIT = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_RD_WAIT,
        ST_WR_WAIT,
        ST_WR_DATA,
        ST_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        RX_DATA,
        RX_ACT,
        RX_STAT,
        RX_OTHER
    } rx_kind_e;
endpackage

// File: rtl/dfs_rx_decode.sv
module dfs_rx_decode
    import dfs_pkg::*;
(
    input  logic [7:0] rx_type,
    output rx_kind_e   rx_kind
);
    always_comb begin
        unique case (rx_type)
            FIS_DATA:    rx_kind = RX_DATA;
            FIS_DMA_ACT: rx_kind = RX_ACT;
            FIS_REG_D2H: rx_kind = RX_STAT;
            default:     rx_kind = RX_OTHER;
        endcase
    end
endmodule

// File: rtl/dfs_remain.sv
module dfs_remain #(
    parameter int REM_W         = 25,
    parameter int LEN_W         = 14,
    parameter int MAX_FIS_BYTES = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REM_W-1:0] load_bytes,
    input  logic             consume,
    output logic [LEN_W-1:0] chunk,
    output logic             rem_zero
);
    localparam logic [REM_W-1:0] MAX_REM = REM_W'(MAX_FIS_BYTES);

    logic [REM_W-1:0] rem_q;

    always_comb begin
        if (rem_q > MAX_REM) begin
            chunk = LEN_W'(MAX_FIS_BYTES);
        end else begin
            chunk = rem_q[LEN_W-1:0];
        end
        rem_zero = (rem_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_bytes;
        end else if (consume) begin
            rem_q <= rem_q - REM_W'(chunk);
        end
    end
endmodule

// File: rtl/dfs_fsm.sv
module dfs_fsm
    import dfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic       wr_q,
    input  logic       tx_ready,
    input  logic       rx_valid,
    input  rx_kind_e   rx_kind,
    input  logic       rx_err,
    input  logic       rem_zero,
    output seq_state_e state,
    output logic       cmd_ready,
    output logic       tx_valid,
    output logic       tx_is_data,
    output logic       rx_ready,
    output logic       done,
    output logic       done_err,
    output logic       load,
    output logic       consume
);
    seq_state_e state_q, state_d;
    logic       err_q, err_d;

    // next state and error flag
    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        unique case (state_q)
            ST_IDLE: begin
                err_d = 1'b0;
                if (cmd_valid) state_d = ST_CMD;
            end
            ST_CMD: begin
                if (tx_ready) state_d = wr_q ? ST_WR_WAIT : ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (rx_valid) begin
                    unique case (rx_kind)
                        RX_DATA: state_d = ST_RD_WAIT;
                        RX_STAT: begin
                            state_d = ST_FINISH;
                            err_d   = rx_err;
                        end
                        default: begin
                            state_d = ST_FINISH;
                            err_d   = 1'b1;
                        end
                    endcase
                end
            end
            ST_WR_WAIT: begin
                if (rx_valid) begin
                    unique case (rx_kind)
                        RX_ACT: begin
                            if (rem_zero) begin
                                state_d = ST_FINISH;
                                err_d   = 1'b1;
                            end else begin
                                state_d = ST_WR_DATA;
                            end
                        end
                        RX_STAT: begin
                            state_d = ST_FINISH;
                            err_d   = rx_err;
                        end
                        default: begin
                            state_d = ST_FINISH;
                            err_d   = 1'b1;
                        end
                    endcase
                end
            end
            ST_WR_DATA: begin
                if (tx_ready) state_d = ST_WR_WAIT;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    // outputs
    always_comb begin
        cmd_ready  = 1'b0;
        tx_valid   = 1'b0;
        tx_is_data = 1'b0;
        rx_ready   = 1'b0;
        done       = 1'b0;
        load       = 1'b0;
        consume    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                load      = cmd_valid;
            end
            ST_CMD: begin
                tx_valid = 1'b1;
            end
            ST_RD_WAIT, ST_WR_WAIT: begin
                rx_ready = 1'b1;
            end
            ST_WR_DATA: begin
                tx_valid   = 1'b1;
                tx_is_data = 1'b1;
                consume    = tx_ready;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: begin
                cmd_ready = 1'b0;
            end
        endcase
        done_err = done & err_q;
        state    = state_q;
    end
endmodule

// File: rtl/dma_fis_seq.sv
module dma_fis_seq
    import dfs_pkg::*;
#(
    parameter int SEC_W         = 16,
    parameter int SECT_BYTES    = 512,
    parameter int MAX_FIS_BYTES = 8192,
    localparam int LEN_W        = $clog2(MAX_FIS_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [7:0]       cmd_opcode,
    input  logic             cmd_write,
    input  logic [SEC_W-1:0] cmd_sectors,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [7:0]       tx_type,
    output logic [7:0]       tx_opcode,
    output logic             tx_write,
    output logic [LEN_W-1:0] tx_len,
    input  logic             rx_valid,
    output logic             rx_ready,
    input  logic [7:0]       rx_type,
    input  logic [7:0]       rx_status,
    output logic             done,
    output logic             done_err,
    output logic             busy
);
    localparam int SB_W  = $clog2(SECT_BYTES);
    localparam int REM_W = SEC_W + SB_W;

    seq_state_e       state;
    rx_kind_e         rx_kind;
    logic             load, consume, rem_zero, tx_is_data;
    logic [LEN_W-1:0] chunk;
    logic [7:0]       opcode_q;
    logic             wr_q;
    logic [REM_W-1:0] load_bytes;

    assign load_bytes = REM_W'(cmd_sectors) << SB_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode_q <= '0;
            wr_q     <= 1'b0;
        end else if (load) begin
            opcode_q <= cmd_opcode;
            wr_q     <= cmd_write;
        end
    end

    dfs_rx_decode u_dec (
        .rx_type (rx_type),
        .rx_kind (rx_kind)
    );

    dfs_remain #(
        .REM_W         (REM_W),
        .LEN_W         (LEN_W),
        .MAX_FIS_BYTES (MAX_FIS_BYTES)
    ) u_rem (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_bytes (load_bytes),
        .consume    (consume),
        .chunk      (chunk),
        .rem_zero   (rem_zero)
    );

    dfs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .wr_q       (wr_q),
        .tx_ready   (tx_ready),
        .rx_valid   (rx_valid),
        .rx_kind    (rx_kind),
        .rx_err     (rx_status[STATUS_ERR_BIT]),
        .rem_zero   (rem_zero),
        .state      (state),
        .cmd_ready  (cmd_ready),
        .tx_valid   (tx_valid),
        .tx_is_data (tx_is_data),
        .rx_ready   (rx_ready),
        .done       (done),
        .done_err   (done_err),
        .load       (load),
        .consume    (consume)
    );

    assign tx_type   = tx_is_data ? FIS_DATA : FIS_REG_H2D;
    assign tx_opcode = opcode_q;
    assign tx_write  = wr_q;
    assign tx_len    = tx_is_data ? chunk : '0;
    assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/dfs_chk.sv
module dfs_chk #(
    parameter int MAX_FIS_BYTES = 8192,
    parameter int LEN_W         = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_type,
    input logic [LEN_W-1:0] tx_len,
    input logic             rx_ready,
    input logic             done
);
    // R2
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_type) && $stable(tx_len));

    // R3
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_ready);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    send_not_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && rx_ready));

    // R7
    data_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_type == 8'h46 |-> tx_len != '0 && tx_len <= LEN_W'(MAX_FIS_BYTES));

    // R9
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cmd_ready);
endmodule

bind dma_fis_seq dfs_chk #(
    .MAX_FIS_BYTES (MAX_FIS_BYTES),
    .LEN_W         (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_type   (tx_type),
    .tx_len    (tx_len),
    .rx_ready  (rx_ready),
    .done      (done)
);

// File: tb/sim_dma_fis_seq.sv
`timescale 1ns/1ps
module sim_dma_fis_seq;
    localparam int SEC_W = 16;
    localparam int LEN_W = 14;
    localparam int MAXB  = 8192;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [7:0]       cmd_opcode = '0;
    logic             cmd_write = 1'b0;
    logic [SEC_W-1:0] cmd_sectors = '0;
    logic             tx_valid;
    logic             tx_ready = 1'b0;
    logic [7:0]       tx_type;
    logic [7:0]       tx_opcode;
    logic             tx_write;
    logic [LEN_W-1:0] tx_len;
    logic             rx_valid = 1'b0;
    logic             rx_ready;
    logic [7:0]       rx_type = '0;
    logic [7:0]       rx_status = '0;
    logic             done, done_err, busy;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_fis_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_opcode(cmd_opcode), .cmd_write(cmd_write), .cmd_sectors(cmd_sectors),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_type(tx_type),
        .tx_opcode(tx_opcode), .tx_write(tx_write), .tx_len(tx_len),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_type(rx_type),
        .rx_status(rx_status), .done(done), .done_err(done_err), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] op, input bit wr, input int sec);
        cmd_valid   = 1'b1;
        cmd_opcode  = op;
        cmd_write   = wr;
        cmd_sectors = SEC_W'(sec);
        chk(cmd_ready == 1'b1, "R9 ready before request", int'(cmd_ready), 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(tx_valid && tx_type == 8'h27, "R2 command frame", int'(tx_type), 8'h27);
        chk(tx_opcode == op, "R2 opcode", int'(tx_opcode), int'(op));
        chk(tx_write == wr, "R2 direction", int'(tx_write), int'(wr));
        @(negedge clk);
        chk(tx_valid && tx_opcode == op, "R2 held until ready", int'(tx_valid), 1);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] typ, input logic [7:0] st);
        chk(rx_ready == 1'b1, "R4 rx_ready in wait state", int'(rx_ready), 1);
        rx_valid  = 1'b1;
        rx_type   = typ;
        rx_status = st;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic take_data(input int exp_len);
        chk(tx_valid && tx_type == 8'h46, "R6 one Data FIS after activate", int'(tx_type), 8'h46);
        chk(int'(tx_len) == exp_len, "R7 Data FIS length", int'(tx_len), exp_len);
        chk(rx_ready == 1'b0, "R6 no rx while sending", int'(rx_ready), 0);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic expect_done(input bit err, input string req);
        chk(done == 1'b1, req, int'(done), 1);
        chk(done_err == err, req, int'(done_err), int'(err));
        @(negedge clk);
        chk(done == 1'b0, "R5 done one cycle", int'(done), 0);
        chk(cmd_ready == 1'b1 && busy == 1'b0, "R9 idle after done", int'(cmd_ready), 1);
    endtask

    task automatic run_write(input int sec, input int stop_after, input logic [7:0] st);
        int rem = sec * 512;
        int sent = 0;
        issue(8'h35, 1'b1, sec);
        repeat (2) begin
            chk(tx_valid == 1'b0, "R6 no data before activate", int'(tx_valid), 0);
            @(negedge clk);
        end
        while (rem > 0 && sent != stop_after) begin
            int l = (rem > MAXB) ? MAXB : rem;
            send_rx(8'h39, 8'h00);
            take_data(l);
            rem -= l;
            sent++;
            chk(tx_valid == 1'b0, "R6 paced by activate", int'(tx_valid), 0);
            @(negedge clk);
            chk(tx_valid == 1'b0 && done == 1'b0, "R6 waits for next activate", int'(tx_valid), 0);
        end
        send_rx(8'h34, st);
        expect_done(st[0], "R5 write status ends command");
    endtask

    task automatic run_read(input int n, input logic [7:0] st);
        issue(8'h25, 1'b0, n);
        for (int i = 0; i < n; i++) begin
            send_rx(8'h46, 8'h00);
            chk(done == 1'b0 && busy == 1'b1, "R4 read data keeps command open", int'(done), 0);
        end
        send_rx(8'h34, st);
        expect_done(st[0], "R5 read status ends command");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(cmd_ready == 1'b1 && busy == 1'b0, "R1 reset idle", int'(cmd_ready), 1);
        chk(tx_valid == 1'b0 && rx_ready == 1'b0 && done == 1'b0, "R1 reset outputs",
            int'(tx_valid), 0);

        // R7 sweep of write lengths, crossing the frame limit
        for (int s = 1; s <= 40; s++) run_write(s, -1, 8'h50);

        // R4 reads with varied data counts, with and without ERR
        for (int n = 0; n <= 6; n++) run_read(n, 8'h50);
        run_read(3, 8'h51);

        // R5 early status with ERR after k frames of a long write
        for (int k = 0; k <= 2; k++) run_write(40, k, 8'h51);

        // R8 activate during read
        issue(8'h25, 1'b0, 4);
        send_rx(8'h46, 8'h00);
        send_rx(8'h39, 8'h00);
        expect_done(1'b1, "R8 activate during read");

        // R8 data during write wait
        issue(8'h35, 1'b1, 4);
        send_rx(8'h46, 8'h00);
        expect_done(1'b1, "R8 data during write wait");

        // R8 host frame type received
        issue(8'h35, 1'b1, 4);
        send_rx(8'h27, 8'h00);
        expect_done(1'b1, "R8 0x27 during write wait");

        // R8 activate with nothing left
        issue(8'h35, 1'b1, 0);
        send_rx(8'h39, 8'h00);
        expect_done(1'b1, "R8 activate with zero remaining");

        // R3 requests while busy are refused
        issue(8'h25, 1'b0, 1);
        cmd_valid  = 1'b1;
        cmd_opcode = 8'hC8;
        repeat (3) begin
            chk(cmd_ready == 1'b0 && tx_valid == 1'b0, "R3 busy refuses request",
                int'(cmd_ready), 0);
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        send_rx(8'h46, 8'h00);
        send_rx(8'h34, 8'h50);
        expect_done(1'b0, "R3 command unaffected");
        repeat (2) begin
            chk(tx_valid == 1'b0 && busy == 1'b0, "R3 refused request not started",
                int'(tx_valid), 0);
            @(negedge clk);
        end
        issue(8'h61, 1'b0, 1);
        send_rx(8'h34, 8'h50);
        expect_done(1'b0, "R3 next command own opcode");

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule